// File: doc/BRIEF.md
# Real-Time Clock Register File

This block is the register file of a watch-style real-time clock. A host reaches it through a plain strobe bus. Fourteen registers are visible. Ten of them form the time and alarm group: the time values come from an internal calendar counter, and the alarm slots read as zero. The other four are control registers A, B, C and D. Each control register has its own write mask, and register D also has a read mask. The calendar counter advances once for each cycle in which the one-pulse-per-second tick input is high.

A year-mode flag chooses what the year register returns: either a fixed compatibility constant or the counted year. Two side-band strobes mark the stored time as valid or invalid. Marking it valid also loads a default configuration into registers A and B. There are two resets. A power-up reset returns the control registers, the calendar and the year mode to their initial state. A soft reset clears only the bus read-data register.

The bus has no back-pressure. Every read or write strobe is accepted in the cycle it is high, and there is no ready signal. Read data is registered and appears in the cycle after the read strobe. It holds its value until the next read or reset.

Top module: `rtc_regfile`

## Requirements
- R1: The register index is bus_addr[4:1]; all other address bits are ignored. Index map: 0 seconds, 1 seconds-alarm, 2 minutes, 3 minutes-alarm, 4 hours, 5 hours-alarm, 6 day-of-week, 7 day-of-month, 8 month, 9 year, 10 control A, 11 control B, 12 control C, 13 control D.
- R2: In control A, only bits [6:0] are writable. Bits [3:0] are rate select and bits [6:4] are divider select. Bit 7 (update busy) keeps its value, which is 0 after power-up.
- R3: In control B, only bits 0 (daylight enable), 1 (24-hour), 2 (binary data) and 7 (set) are writable. Bits 3 to 6 keep their values, which are 0 after power-up.
- R4: Writes to control C are ignored, and control C reads 0.
- R5: In control D, only bit 7 (time valid) is writable. A read of D returns bit 7, and all its other bits read as 0.
- R6: Only bus_wdata[7:0] takes part in a write. The writable bits are replaced and the other bits of the register are kept.
- R7: Read data appears on bus_rdata in the cycle after bus_rd. For an odd index the byte is placed in bits [23:16]; for an even index it is placed in bits [7:0]. All other bits are 0. The value holds until the next read.
- R8: In fixed-year mode the year register reads decimal 82. In standard mode it reads the counted year, 0 to 99. A year_mode_load strobe selects standard mode when year_mode_std=1 and fixed-year mode when year_mode_std=0.
- R9: Power-up reset (por_n low) does the following: control A to D become 0; the time becomes 00:00:00, day-of-week 0, day-of-month 1, month 0, year 0; fixed-year mode is selected. A soft reset (soft_rst_n low) clears bus_rdata and leaves every register unchanged.
- R10: A mark_valid strobe ORs divider value 2 into control A bits [6:4], sets control B bits 1 and 2, and sets control D bit 7. A mark_invalid strobe clears only control D bit 7. If both strobes are high in the same cycle, mark_valid wins.
- R11: Each cycle with tick_1hz high advances the calendar. Seconds run 0 to 59, then minutes 0 to 59, then hours 0 to 23. When the hours wrap, day-of-week (0 to 6) and day-of-month (1 to 31) advance. When the day-of-month wraps, month (0 to 11) advances, and when the month wraps, year (0 to 99) advances.
- R12: The alarm indices 1, 3 and 5 and the unused indices 14 and 15 read 0. Writes to indices 0 to 9 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, synchronous |
| soft_rst_n | input | 1 | Soft reset, active low; clears read data only |
| tick_1hz | input | 1 | Advances the calendar in each cycle it is high |
| year_mode_load | input | 1 | Strobe that loads the year mode |
| year_mode_std | input | 1 | Mode to load: 1 standard, 0 fixed year |
| mark_valid | input | 1 | Strobe: mark the time valid and load the default configuration |
| mark_invalid | input | 1 | Strobe: clear the time-valid flag |
| bus_addr | input | ADDR_W | Bus address; bits [4:1] select the register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WDATA_W | Write data; only the low byte is used |
| bus_rdata | output | RDATA_W | Registered read data |

## Verification
The bench writes all ones to every control register. A design with a wrong mask would show the update-busy bit, the interrupt enables or the stray bits of D in the readback. It also writes data with the upper byte set and checks the result; a design that does not truncate would corrupt the register. It reads odd and even indices and sends an address with junk in bit 0 and the high bits. A wrong lane choice would leave the byte in the wrong half of the read word, and a wrong index decode would select the wrong register. It runs 86,400 ticks and checks the seconds, hour and day carries; a mistake there would show an off-by-one wrap or a day that never advances. It switches the year mode in both directions and issues both resets; a design that mixes up the two resets would clear control state on a soft reset, or keep standard mode after a power-up reset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_FIELDS = 7;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DOM  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef enum logic [3:0] {
    IDX_SEC      = 4'd0,
    IDX_SEC_ALM  = 4'd1,
    IDX_MIN      = 4'd2,
    IDX_MIN_ALM  = 4'd3,
    IDX_HOUR     = 4'd4,
    IDX_HOUR_ALM = 4'd5,
    IDX_DOW      = 4'd6,
    IDX_DOM      = 4'd7,
    IDX_MONTH    = 4'd8,
    IDX_YEAR     = 4'd9,
    IDX_CTL_A    = 4'd10,
    IDX_CTL_B    = 4'd11,
    IDX_CTL_C    = 4'd12,
    IDX_CTL_D    = 4'd13
  } reg_idx_e;

  localparam logic [7:0] WMASK_A   = 8'h7F;
  localparam logic [7:0] WMASK_B   = 8'h87;
  localparam logic [7:0] WMASK_D   = 8'h80;
  localparam logic [7:0] RMASK_D   = 8'h80;
  localparam logic [2:0] DIV_VALID = 3'd2;
  localparam logic [7:0] B_VALID   = 8'h06;
  localparam logic [7:0] FIXED_YEAR = 8'd82;

  // lowest value of each calendar field
  function automatic int field_lo(int f);
    return (f == F_DOM) ? 1 : 0;
  endfunction

  // highest value of each calendar field
  function automatic int field_hi(int f);
    case (f)
      F_SEC, F_MIN: return 59;
      F_HOUR:       return 23;
      F_DOW:        return 6;
      F_DOM:        return 31;
      F_MON:        return 11;
      default:      return 99;
    endcase
  endfunction

  // position in the carry vector that advances field f
  // (carry[0] is the tick, carry[k+1] is the wrap of field k)
  function automatic int carry_src(int f);
    case (f)
      F_DOW, F_DOM: return F_HOUR + 1;
      default:      return f;
    endcase
  endfunction

endpackage

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
  parameter int W  = 8,
  parameter int LO = 0,
  parameter int HI = 59
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap
);

  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  always_ff @(posedge clk) begin
    if (!por_n)
      value <= LO_V;
    else if (inc)
      value <= (value == HI_V) ? LO_V : value + 1'b1;
  end

  assign wrap = inc && (value == HI_V);

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                          clk,
  input  logic                          por_n,
  input  logic                          tick,
  output logic [NUM_FIELDS-1:0][W-1:0]  fields
);

  logic [NUM_FIELDS:0] carry;
  logic                unused_carry;

  assign carry[0] = tick;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    rtc_wrap_cnt #(
      .W  (W),
      .LO (field_lo(g)),
      .HI (field_hi(g))
    ) u_cnt (
      .clk   (clk),
      .por_n (por_n),
      .inc   (carry[carry_src(g)]),
      .value (fields[g]),
      .wrap  (carry[g+1])
    );
  end

  // day-of-week and year wraps carry nowhere
  assign unused_carry = ^carry;

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [3:0] wr_idx,
  input  logic [7:0] wr_byte,
  input  logic       mark_valid,
  input  logic       mark_invalid,
  output logic [7:0] ctrl_a,
  output logic [7:0] ctrl_b,
  output logic [7:0] ctrl_d
);

  logic [7:0] a_n, b_n, d_n;

  always_comb begin
    a_n = ctrl_a;
    b_n = ctrl_b;
    d_n = ctrl_d;
    if (wr_en) begin
      case (wr_idx)
        IDX_CTL_A: a_n = (ctrl_a & ~WMASK_A) | (wr_byte & WMASK_A);
        IDX_CTL_B: b_n = (ctrl_b & ~WMASK_B) | (wr_byte & WMASK_B);
        IDX_CTL_D: d_n = (ctrl_d & ~WMASK_D) | (wr_byte & WMASK_D);
        default: ;
      endcase
    end
    if (mark_invalid)
      d_n[7] = 1'b0;
    if (mark_valid) begin
      a_n[6:4] = a_n[6:4] | DIV_VALID;
      b_n      = b_n | B_VALID;
      d_n[7]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      ctrl_a <= '0;
      ctrl_b <= '0;
      ctrl_d <= '0;
    end else begin
      ctrl_a <= a_n;
      ctrl_b <= b_n;
      ctrl_d <= d_n;
    end
  end

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]                   idx,
  input  logic [NUM_FIELDS-1:0][W-1:0] fields,
  input  logic                         fixed_year,
  input  logic [7:0]                   ctrl_a,
  input  logic [7:0]                   ctrl_b,
  input  logic [7:0]                   ctrl_d,
  output logic [7:0]                   rd_byte
);

  always_comb begin
    case (idx)
      IDX_SEC:   rd_byte = 8'(fields[F_SEC]);
      IDX_MIN:   rd_byte = 8'(fields[F_MIN]);
      IDX_HOUR:  rd_byte = 8'(fields[F_HOUR]);
      IDX_DOW:   rd_byte = 8'(fields[F_DOW]);
      IDX_DOM:   rd_byte = 8'(fields[F_DOM]);
      IDX_MONTH: rd_byte = 8'(fields[F_MON]);
      IDX_YEAR:  rd_byte = fixed_year ? FIXED_YEAR : 8'(fields[F_YEAR]);
      IDX_CTL_A: rd_byte = ctrl_a;
      IDX_CTL_B: rd_byte = ctrl_b;
      IDX_CTL_D: rd_byte = ctrl_d & RMASK_D;
      default:   rd_byte = 8'h00;  // alarms, C, unused
    endcase
  end

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WDATA_W = 16,
  parameter int RDATA_W = 32,
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               soft_rst_n,
  input  logic               tick_1hz,
  input  logic               year_mode_load,
  input  logic               year_mode_std,
  input  logic               mark_valid,
  input  logic               mark_invalid,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [WDATA_W-1:0] bus_wdata,
  output logic [RDATA_W-1:0] bus_rdata
);

  localparam int ODD_SHIFT = RDATA_W / 2;

  logic [3:0]                        reg_idx;
  logic [7:0]                        wr_byte;
  logic [7:0]                        rd_byte;
  logic [7:0]                        ctrl_a, ctrl_b, ctrl_d;
  logic                              fixed_year_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields;
  logic                              unused_bits;

  assign reg_idx = bus_addr[4:1];
  assign wr_byte = bus_wdata[7:0];
  assign unused_bits = ^{bus_addr[0], bus_addr[ADDR_W-1:5], bus_wdata[WDATA_W-1:8]};

  rtc_time_chain #(.W(FIELD_W)) u_chain (
    .clk    (clk),
    .por_n  (por_n),
    .tick   (tick_1hz),
    .fields (fields)
  );

  rtc_ctrl_regs u_ctrl (
    .clk          (clk),
    .por_n        (por_n),
    .wr_en        (bus_wr),
    .wr_idx       (reg_idx),
    .wr_byte      (wr_byte),
    .mark_valid   (mark_valid),
    .mark_invalid (mark_invalid),
    .ctrl_a       (ctrl_a),
    .ctrl_b       (ctrl_b),
    .ctrl_d       (ctrl_d)
  );

  rtc_read_mux #(.W(FIELD_W)) u_mux (
    .idx        (reg_idx),
    .fields     (fields),
    .fixed_year (fixed_year_q),
    .ctrl_a     (ctrl_a),
    .ctrl_b     (ctrl_b),
    .ctrl_d     (ctrl_d),
    .rd_byte    (rd_byte)
  );

  always_ff @(posedge clk) begin
    if (!por_n)
      fixed_year_q <= 1'b1;
    else if (year_mode_load)
      fixed_year_q <= !year_mode_std;
  end

  always_ff @(posedge clk) begin
    if (!por_n || !soft_rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= RDATA_W'(rd_byte) << (reg_idx[0] ? ODD_SHIFT : 0);
  end

endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
  parameter int RDATA_W = 32
) (
  input logic               clk,
  input logic               por_n,
  input logic               soft_rst_n,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [3:0]         reg_idx,
  input logic [RDATA_W-1:0] bus_rdata,
  input logic               mark_valid,
  input logic               mark_invalid,
  input logic               fixed_year_q,
  input logic [7:0]         ctrl_a,
  input logic [7:0]         ctrl_b,
  input logic [7:0]         ctrl_d,
  input logic [7:0]         sec_val
);

  localparam int H = RDATA_W / 2;
  logic unused_chk;
  assign unused_chk = ^{bus_rdata, ctrl_b};

  // R7: odd index lands in the upper half, lower half zero
  a_r7_odd_lane: assert property (@(posedge clk) disable iff (!por_n)
    bus_rd && reg_idx[0] |=> bus_rdata[H-1:0] == '0 && bus_rdata[RDATA_W-1:H+8] == '0);

  // R7: even index lands in the low byte
  a_r7_even_lane: assert property (@(posedge clk) disable iff (!por_n)
    bus_rd && !reg_idx[0] |=> bus_rdata[RDATA_W-1:8] == '0);

  // R2: update-busy bit always reads 0
  a_r2_busy_zero: assert property (@(posedge clk) disable iff (!por_n)
    bus_rd && reg_idx == 4'd10 |=> !bus_rdata[7]);

  // R4: control C reads 0
  a_r4_c_zero: assert property (@(posedge clk) disable iff (!por_n)
    bus_rd && reg_idx == 4'd12 |=> bus_rdata == '0);

  // R5: control D read shows bit 7 only
  a_r5_d_masked: assert property (@(posedge clk) disable iff (!por_n)
    bus_rd && reg_idx == 4'd13 |=> bus_rdata[H+6:H] == '0);

  // R8: fixed-year mode returns the constant
  a_r8_fixed_year: assert property (@(posedge clk) disable iff (!por_n)
    bus_rd && soft_rst_n && reg_idx == 4'd9 && fixed_year_q |=> bus_rdata[H+7:H] == 8'd82);

  // R9: soft reset keeps the control registers
  a_r9_soft_keeps: assert property (@(posedge clk) disable iff (!por_n)
    !soft_rst_n && !bus_wr && !mark_valid && !mark_invalid
    |=> $stable(ctrl_a) && $stable(ctrl_b) && $stable(ctrl_d));

  // R10: mark valid sets the default configuration
  a_r10_mark_valid: assert property (@(posedge clk) disable iff (!por_n)
    mark_valid |=> ctrl_d[7] && ctrl_a[5] && ctrl_b[2] && ctrl_b[1]);

  // R11: seconds stay in range
  a_r11_sec_range: assert property (@(posedge clk) disable iff (!por_n)
    sec_val <= 8'd59);

endmodule

bind rtc_regfile rtc_regfile_chk #(.RDATA_W(RDATA_W)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .soft_rst_n   (soft_rst_n),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .reg_idx      (reg_idx),
  .bus_rdata    (bus_rdata),
  .mark_valid   (mark_valid),
  .mark_invalid (mark_invalid),
  .fixed_year_q (fixed_year_q),
  .ctrl_a       (ctrl_a),
  .ctrl_b       (ctrl_b),
  .ctrl_d       (ctrl_d),
  .sec_val      (fields[0])
);

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, soft_rst_n = 1'b1, tick_1hz = 1'b0;
  logic        year_mode_load = 1'b0, year_mode_std = 1'b0;
  logic        mark_valid = 1'b0, mark_invalid = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regfile i_rtc_regfile (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .tick_1hz(tick_1hz),
    .year_mode_load(year_mode_load), .year_mode_std(year_mode_std),
    .mark_valid(mark_valid), .mark_invalid(mark_invalid),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] lane(int idx, logic [7:0] b);
    return (idx % 2 == 1) ? {8'h00, b, 16'h0000} : {24'h0, b};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd_raw(logic [7:0] addr, output logic [31:0] v);
    @(negedge clk); bus_addr = addr; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic rd_chk(string req, int idx, logic [7:0] exp);
    logic [31:0] v;
    rd_raw(8'(idx * 2), v);
    check(req, v, lane(idx, exp));
  endtask

  task automatic wr(int idx, logic [15:0] d);
    @(negedge clk); bus_addr = 8'(idx * 2); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic pulse_por();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick_1hz = 1'b1;
    repeat (n) @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic t_reset_state();
    rd_chk("R9 A after power-up", 10, 8'h00);
    rd_chk("R9 B after power-up", 11, 8'h00);
    rd_chk("R9 C after power-up", 12, 8'h00);
    rd_chk("R9 D after power-up", 13, 8'h00);
    rd_chk("R9 year fixed after power-up", 9, 8'd82);
    rd_chk("R9 seconds after power-up", 0, 8'd0);
    rd_chk("R9 day-of-month after power-up", 7, 8'd1);
  endtask

  task automatic t_masks();
    wr(10, 16'h00FF); rd_chk("R2 A write all ones", 10, 8'h7F);
    wr(11, 16'h00FF); rd_chk("R3 B write all ones", 11, 8'h87);
    wr(11, 16'h0000); rd_chk("R3 B write zero", 11, 8'h00);
    wr(12, 16'h00FF); rd_chk("R4 C ignores write", 12, 8'h00);
    wr(13, 16'h00FF); rd_chk("R5 D read bit7 only", 13, 8'h80);
    wr(13, 16'h007F); rd_chk("R5 D clear", 13, 8'h00);
    wr(10, 16'hFF35); rd_chk("R6 A upper byte dropped", 10, 8'h35);
  endtask

  task automatic t_lanes();
    logic [31:0] v;
    rd_raw(8'hE1 | 8'(10 * 2), v);
    check("R1 junk address bits ignored", v, 32'h0000_0035);
    wr(11, 16'h0081);
    check("R7 rdata holds without read", bus_rdata, 32'h0000_0035);
    rd_chk("R7 odd index upper lane", 11, 8'h81);
    wr(11, 16'h0000);
  endtask

  task automatic t_mark();
    wr(10, 16'h0041);
    @(negedge clk); mark_valid = 1'b1;
    @(negedge clk); mark_valid = 1'b0;
    rd_chk("R10 mark valid A", 10, 8'h61);
    rd_chk("R10 mark valid B", 11, 8'h06);
    rd_chk("R10 mark valid D", 13, 8'h80);
    @(negedge clk); mark_invalid = 1'b1;
    @(negedge clk); mark_invalid = 1'b0;
    rd_chk("R10 mark invalid D", 13, 8'h00);
    rd_chk("R10 mark invalid keeps A", 10, 8'h61);
  endtask

  task automatic t_alarm_ignored();
    rd_chk("R12 seconds alarm reads 0", 1, 8'h00);
    rd_chk("R12 hours alarm reads 0", 5, 8'h00);
    rd_chk("R12 index 15 reads 0", 15, 8'h00);
    wr(0, 16'h0030); wr(3, 16'h0011);
    rd_chk("R12 seconds write ignored", 0, 8'd0);
    rd_chk("R12 alarm write ignored", 3, 8'h00);
  endtask

  task automatic t_time();
    ticks(59);    rd_chk("R11 seconds at 59", 0, 8'd59);
    ticks(1);     rd_chk("R11 seconds wrap", 0, 8'd0);
                  rd_chk("R11 minute carry", 2, 8'd1);
    ticks(3540);  rd_chk("R11 hour carry", 4, 8'd1);
                  rd_chk("R11 minutes wrap", 2, 8'd0);
    ticks(82800); rd_chk("R11 hours wrap", 4, 8'd0);
                  rd_chk("R11 day-of-week advance", 6, 8'd1);
                  rd_chk("R11 day-of-month advance", 7, 8'd2);
                  rd_chk("R11 month unchanged", 8, 8'd0);
  endtask

  task automatic t_year_mode();
    @(negedge clk); year_mode_load = 1'b1; year_mode_std = 1'b1;
    @(negedge clk); year_mode_load = 1'b0;
    rd_chk("R8 standard year", 9, 8'd0);
    @(negedge clk); year_mode_load = 1'b1; year_mode_std = 1'b0;
    @(negedge clk); year_mode_load = 1'b0;
    rd_chk("R8 fixed year again", 9, 8'd82);
  endtask

  task automatic t_resets();
    wr(10, 16'h0033);
    wr(13, 16'h0080);
    rd_chk("R9 setup A", 10, 8'h33);
    @(negedge clk); soft_rst_n = 1'b0;
    @(negedge clk); soft_rst_n = 1'b1;
    check("R9 soft reset clears rdata", bus_rdata, 32'h0);
    rd_chk("R9 soft reset keeps A", 10, 8'h33);
    rd_chk("R9 soft reset keeps D", 13, 8'h80);
    @(negedge clk); year_mode_load = 1'b1; year_mode_std = 1'b1;
    @(negedge clk); year_mode_load = 1'b0;
    pulse_por();
    rd_chk("R9 power-up clears A", 10, 8'h00);
    rd_chk("R9 power-up clears D", 13, 8'h00);
    rd_chk("R9 power-up restores fixed year", 9, 8'd82);
    rd_chk("R9 power-up clears day", 7, 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_reset_state();
    t_masks();
    t_lanes();
    t_mark();
    t_alarm_ignored();
    t_time();
    t_year_mode();
    t_resets();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule